// File: doc/BRIEF.md
# Block-Indexed Branch Target Predictor with Response Lane Masking

This block sits beside the fetch address path of a superscalar front end that fetches aligned blocks of several instruction lanes at a time. Each fetch request presents the base address of its block. The block looks that address up in a set-associative target table. When an entry matches and its 2-bit direction counter leans taken, the block raises a redirect with the stored target in the same cycle, so the address generator can steer the next fetch.

For every request it accepts, the block stores the prediction outcome and the branch lane in a small in-order metadata queue. When the matching memory response comes back, it pops that record. It then tells the fetch path which lanes still carry useful instructions: lanes after a predicted-taken branch are switched off, and the branch lane itself is marked as predicted taken.

Branches resolved further down the pipeline train the table. A hit moves the saturating counter. A miss allocates an entry, choosing the victim way in each set in round-robin (first-in, first-out) order. A flush throws away the queued metadata of responses that will be squashed.

Top module: `btb_predictor`

## Requirements
- R1: After reset no entry is valid, so no request raises `pred_val`. `req_rdy` is 1, and with an empty queue `rsp_lane_active` is all ones and `rsp_lane_pred_taken` is all zeros.
- R2: A request with `req_val`=1 and `req_rdy`=1 hits an entry when that entry is valid in the set selected by the block address bits directly above the in-block byte offset (bits [6:4] at default parameters) and its tag equals the bits above those (bits [31:7]). On a hit whose counter has MSB 1, `pred_val` is 1 in that same cycle and `pred_target` equals the stored target.
- R3: A hit whose counter has MSB 0, or a miss, leaves `pred_val` at 0, and the matching response reports every lane active.
- R4: A resolved-branch update (`upd_val`) that misses allocates an entry. The entry takes its tag and set from `upd_pc`, its branch lane from `upd_pc` bits [3:2], and its target from `upd_target`. Its counter starts at 2'b10 if `upd_taken`=1, otherwise at 2'b01.
- R5: An update that hits increments the counter when taken and decrements it when not taken, saturating at 2'b11 and 2'b00. A taken update on a hit also rewrites the stored target and branch lane.
- R6: Each set replaces its ways in allocation order: a way is never reused while an older one in the same set has not been replaced. Allocation in one set leaves the entries of other sets unchanged.
- R7: Response metadata is returned in request order: each `rsp_val` pops the record of the oldest accepted request still queued.
- R8: For a popped record that predicted taken with branch lane L, `rsp_lane_active` has bits 0..L set and higher bits clear, and `rsp_lane_pred_taken` has only bit L set.
- R9: While `FIFO_DEPTH` records are queued, `req_rdy` is 0. A request in that state is not recorded and raises no `pred_val`, even if it would hit taken.
- R10: `flush` discards every queued record; a pop in the same cycle has no effect, and a request accepted in the same cycle is kept as the only record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_val | input | 1 | Fetch request presented this cycle |
| req_addr | input | ADDR_W | Fetch-block base address |
| req_rdy | output | 1 | Metadata queue has room; request is accepted |
| pred_val | output | 1 | Predicted-taken redirect for the accepted request |
| pred_target | output | ADDR_W | Redirect target address |
| rsp_val | input | 1 | Memory response returning; pops one record |
| rsp_lane_active | output | NUM_LANES | Lanes holding useful instructions for the head record |
| rsp_lane_pred_taken | output | NUM_LANES | Lane holding the predicted-taken branch |
| flush | input | 1 | Discard queued metadata |
| upd_val | input | 1 | Resolved branch update |
| upd_pc | input | ADDR_W | Address of the resolved branch instruction |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | ADDR_W | Resolved target address |

## Verification
The bench walks one counter through every state, driving updates against both saturation limits. A wrong saturation would wrap 2'b11 to 2'b00 and lose the taken prediction. Four blocks that share one set force two evictions. A victim pointer that ignores age, or that is shared between sets, would evict the wrong way or damage the other set's entry. The bench fills the queue to its depth to check that a taken hit on a full queue stays silent. It also flushes with and without a same-cycle request; a flush that forgets pending records would let a stale branch lane mask the next response.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_e;

  function automatic logic [1:0] ctr_train(input logic [1:0] c, input logic taken);
    if (taken) return (c == CTR_STRONG_T)  ? c : c + 2'd1;
    else       return (c == CTR_STRONG_NT) ? c : c - 2'd1;
  endfunction

endpackage

// File: rtl/btb_table.sv
module btb_table
  import btb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_LANES   = 4,
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_WAYS    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            lk_addr,
  output logic                         lk_hit,
  output logic                         lk_taken,
  output logic [ADDR_W-1:0]            lk_target,
  output logic [$clog2(NUM_LANES)-1:0] lk_lane,
  input  logic                         up_val,
  input  logic [ADDR_W-1:0]            up_pc,
  input  logic                         up_taken,
  input  logic [ADDR_W-1:0]            up_target
);

  localparam int LANE_BITS = $clog2(NUM_LANES);
  localparam int NUM_SETS  = NUM_ENTRIES / NUM_WAYS;
  localparam int IDX_USED  = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 0;
  localparam int SET_BITS  = (NUM_SETS > 1) ? IDX_USED : 1;
  localparam int WAY_BITS  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
  localparam int ENT_BITS  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int OFS       = 2 + LANE_BITS;
  localparam int TAG_LSB   = OFS + IDX_USED;
  localparam int TAG_W     = ADDR_W - TAG_LSB;

  // storage
  logic [NUM_ENTRIES-1:0] ent_v;
  logic [TAG_W-1:0]       ent_tag  [NUM_ENTRIES];
  logic [ADDR_W-1:0]      ent_tgt  [NUM_ENTRIES];
  logic [1:0]             ent_ctr  [NUM_ENTRIES];
  logic [LANE_BITS-1:0]   ent_lane [NUM_ENTRIES];
  logic [WAY_BITS-1:0]    rr_ptr   [NUM_SETS];

  logic [SET_BITS-1:0] lk_set, up_set;
  logic [TAG_W-1:0]    lk_tag, up_tag;
  logic                unused_bits;

  assign lk_tag      = lk_addr[ADDR_W-1:TAG_LSB];
  assign up_tag      = up_pc[ADDR_W-1:TAG_LSB];
  assign unused_bits = ^{lk_addr[OFS-1:0], up_pc[1:0]};

  generate
    if (NUM_SETS > 1) begin : g_indexed
      assign lk_set = lk_addr[OFS +: SET_BITS];
      assign up_set = up_pc[OFS +: SET_BITS];
    end else begin : g_single_set
      assign lk_set = '0;
      assign up_set = '0;
    end
  endgenerate

  function automatic logic [ENT_BITS-1:0] slot(input logic [SET_BITS-1:0] s, input int w);
    return ENT_BITS'(int'(s) * NUM_WAYS + w);
  endfunction

  // lookup
  logic [WAY_BITS-1:0] lk_way;
  logic [ENT_BITS-1:0] lk_sl;

  always_comb begin
    lk_hit = 1'b0;
    lk_way = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (!lk_hit && ent_v[slot(lk_set, w)] && ent_tag[slot(lk_set, w)] == lk_tag) begin
        lk_hit = 1'b1;
        lk_way = WAY_BITS'(w);
      end
    end
  end

  assign lk_sl     = slot(lk_set, int'(lk_way));
  assign lk_taken  = lk_hit & ent_ctr[lk_sl][1];
  assign lk_target = ent_tgt[lk_sl];
  assign lk_lane   = ent_lane[lk_sl];

  // update next-state
  logic                up_hit;
  logic [WAY_BITS-1:0] up_way, wr_way, rr_nxt;
  logic [ENT_BITS-1:0] wr_sl;
  logic [1:0]          ctr_nxt;
  logic                alloc, fld_en;

  always_comb begin
    up_hit = 1'b0;
    up_way = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (!up_hit && ent_v[slot(up_set, w)] && ent_tag[slot(up_set, w)] == up_tag) begin
        up_hit = 1'b1;
        up_way = WAY_BITS'(w);
      end
    end
  end

  always_comb begin
    alloc   = up_val & ~up_hit;
    fld_en  = up_val & (~up_hit | up_taken);
    wr_way  = up_hit ? up_way : rr_ptr[up_set];
    wr_sl   = slot(up_set, int'(wr_way));
    ctr_nxt = up_hit ? ctr_train(ent_ctr[wr_sl], up_taken)
                     : (up_taken ? CTR_WEAK_T : CTR_WEAK_NT);
    rr_nxt  = (rr_ptr[up_set] == WAY_BITS'(NUM_WAYS - 1)) ? '0 : rr_ptr[up_set] + 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v <= '0;
    end else if (alloc) begin
      ent_v[wr_sl] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) rr_ptr[s] <= '0;
    end else if (alloc) begin
      rr_ptr[up_set] <= rr_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (up_val) ent_ctr[wr_sl] <= ctr_nxt;
    if (fld_en) begin
      ent_tag[wr_sl]  <= up_tag;
      ent_tgt[wr_sl]  <= up_target;
      ent_lane[wr_sl] <= up_pc[2 +: LANE_BITS];
    end
  end

  // a fresh entry is valid and starts at a weak counter state
  p_alloc_weak_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> ent_v[$past(wr_sl)] &&
              ent_ctr[$past(wr_sl)] == ($past(up_taken) ? 2'b10 : 2'b01));

  // strongly taken stays strongly taken under another taken outcome
  p_ctr_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_val && up_hit && up_taken && ent_ctr[wr_sl] == 2'b11) |=> ent_ctr[$past(wr_sl)] == 2'b11);

  // the victim pointer never leaves the way range
  p_rr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    up_val |-> int'(rr_ptr[up_set]) < NUM_WAYS);

endmodule

// File: rtl/btb_meta_fifo.sv
module btb_meta_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         flush,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty & ~flush;
  assign dout    = mem[rd_ptr];

  always_comb begin
    wr_nxt = do_push ? inc(wr_ptr) : wr_ptr;
    if (flush) begin
      rd_nxt  = wr_ptr;
      cnt_nxt = do_push ? CNT_W'(1) : '0;
    end else begin
      rd_nxt  = do_pop ? inc(rd_ptr) : rd_ptr;
      cnt_nxt = cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      rd_ptr <= rd_nxt;
      wr_ptr <= wr_nxt;
      cnt    <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);

  p_flush_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt == ($past(push && !full) ? CNT_W'(1) : CNT_W'(0)));

endmodule

// File: rtl/btb_lane_mask.sv
module btb_lane_mask #(
  parameter int NUM_LANES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rec_val,
  input  logic                         rec_taken,
  input  logic [$clog2(NUM_LANES)-1:0] rec_lane,
  output logic [NUM_LANES-1:0]         lane_active,
  output logic [NUM_LANES-1:0]         lane_pt
);

  localparam int LANE_BITS = $clog2(NUM_LANES);

  logic cut;
  assign cut = rec_val & rec_taken;

  generate
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      assign lane_active[i] = ~cut | (LANE_BITS'(i) <= rec_lane);
      assign lane_pt[i]     = cut & (rec_lane == LANE_BITS'(i));
    end
  endgenerate

  p_single_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_pt));

  p_flag_on_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_pt & ~lane_active) == '0);

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ADDR_W      = 32,
  parameter int NUM_LANES   = 4,
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_WAYS    = 2,
  parameter int FIFO_DEPTH  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_val,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 req_rdy,
  output logic                 pred_val,
  output logic [ADDR_W-1:0]    pred_target,
  input  logic                 rsp_val,
  output logic [NUM_LANES-1:0] rsp_lane_active,
  output logic [NUM_LANES-1:0] rsp_lane_pred_taken,
  input  logic                 flush,
  input  logic                 upd_val,
  input  logic [ADDR_W-1:0]    upd_pc,
  input  logic                 upd_taken,
  input  logic [ADDR_W-1:0]    upd_target
);

  localparam int LANE_BITS = $clog2(NUM_LANES);
  localparam int META_W    = LANE_BITS + 1;

  logic                 lk_hit, lk_taken, fire;
  logic [LANE_BITS-1:0] lk_lane;
  logic [META_W-1:0]    head;
  logic                 q_full, q_empty;

  btb_table #(
    .ADDR_W(ADDR_W), .NUM_LANES(NUM_LANES),
    .NUM_ENTRIES(NUM_ENTRIES), .NUM_WAYS(NUM_WAYS)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .lk_addr(req_addr), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .lk_target(pred_target), .lk_lane(lk_lane),
    .up_val(upd_val), .up_pc(upd_pc), .up_taken(upd_taken), .up_target(upd_target)
  );

  assign req_rdy  = ~q_full;
  assign fire     = req_val & req_rdy;
  assign pred_val = fire & lk_taken;

  btb_meta_fifo #(.DEPTH(FIFO_DEPTH), .W(META_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(fire), .pop(rsp_val), .flush(flush),
    .din({lk_taken, lk_lane}), .dout(head),
    .full(q_full), .empty(q_empty)
  );

  btb_lane_mask #(.NUM_LANES(NUM_LANES)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .rec_val(~q_empty), .rec_taken(head[LANE_BITS]), .rec_lane(head[LANE_BITS-1:0]),
    .lane_active(rsp_lane_active), .lane_pt(rsp_lane_pred_taken)
  );

  // a redirect is only ever raised for an accepted request
  p_no_pred_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_rdy |-> !pred_val);

  // a redirect always comes from a table hit
  p_pred_needs_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pred_val |-> lk_hit);

endmodule

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;
  localparam int AW = 32, NL = 4, NE = 16, NW = 2, FD = 4, NS = NE / NW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_val, rsp_val, flush, upd_val, upd_taken;
  logic [AW-1:0] req_addr, upd_pc, upd_target;
  logic          req_rdy, pred_val;
  logic [AW-1:0] pred_target;
  logic [NL-1:0] rsp_lane_active, rsp_lane_pred_taken;

  always #2 clk = ~clk;

  btb_predictor #(.ADDR_W(AW), .NUM_LANES(NL), .NUM_ENTRIES(NE),
                  .NUM_WAYS(NW), .FIFO_DEPTH(FD)) dut (
    .clk(clk), .rst_n(rst_n), .req_val(req_val), .req_addr(req_addr),
    .req_rdy(req_rdy), .pred_val(pred_val), .pred_target(pred_target),
    .rsp_val(rsp_val), .rsp_lane_active(rsp_lane_active),
    .rsp_lane_pred_taken(rsp_lane_pred_taken), .flush(flush),
    .upd_val(upd_val), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
  );

  // bench-side model of the table and the metadata queue
  bit          mv   [NS][NW];
  logic [24:0] mtag [NS][NW];
  logic [31:0] mtgt [NS][NW];
  logic [1:0]  mctr [NS][NW];
  logic [1:0]  mlane[NS][NW];
  int          mrr  [NS];

  typedef struct packed { logic tk; logic [1:0] ln; } meta_t;
  meta_t expq[$];

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic int mfind(input logic [31:0] a);
    for (int w = 0; w < NW; w++)
      if (mv[a[6:4]][w] && mtag[a[6:4]][w] == a[31:7]) return w;
    return -1;
  endfunction

  // monitor: pops the expected record and compares the lane outputs
  task automatic monitor_rsp(input string rq);
    meta_t m;
    logic [3:0] ea, ep;
    m = '0;
    if (expq.size() > 0) m = expq.pop_front();
    ea = 4'hF; ep = 4'h0;
    if (m.tk) begin
      for (int i = 0; i < NL; i++) begin
        ea[i] = (i <= int'(m.ln));
        ep[i] = (i == int'(m.ln));
      end
    end
    chk(rsp_lane_active == ea, rq, "lane_active", 32'(rsp_lane_active), 32'(ea));
    chk(rsp_lane_pred_taken == ep, rq, "lane_pred_taken", 32'(rsp_lane_pred_taken), 32'(ep));
  endtask

  // driver: one cycle of stimulus, checks, model and scoreboard update
  task automatic step(input bit rv, input logic [31:0] ra, input bit sv, input bit fl,
                      input bit uv, input logic [31:0] upc, input bit ut,
                      input logic [31:0] utg, input string rq);
    int w, uw, s, us;
    bit exp_rdy, etk;
    meta_t m;
    @(negedge clk);
    req_val = rv; req_addr = ra; rsp_val = sv; flush = fl;
    upd_val = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
    #1;
    exp_rdy = (expq.size() < FD);
    s = int'(ra[6:4]);
    w = mfind(ra);
    etk = (w >= 0) && mctr[s][w][1];
    chk(req_rdy == exp_rdy, rq, "req_rdy", 32'(req_rdy), 32'(exp_rdy));
    chk(pred_val == (rv && exp_rdy && etk), rq, "pred_val", 32'(pred_val),
        32'(rv && exp_rdy && etk));
    if (rv && exp_rdy && etk) chk(pred_target == mtgt[s][w], rq, "pred_target",
                                  pred_target, mtgt[s][w]);
    if (sv && !fl) monitor_rsp(rq);
    if (fl) expq.delete();
    if (rv && exp_rdy) begin
      m.tk = etk;
      m.ln = (w >= 0) ? mlane[s][w] : 2'd0;
      expq.push_back(m);
    end
    if (uv) begin
      us = int'(upc[6:4]);
      uw = mfind(upc);
      if (uw >= 0) begin
        if (ut) mctr[us][uw] = (mctr[us][uw] == 2'b11) ? 2'b11 : mctr[us][uw] + 2'd1;
        else    mctr[us][uw] = (mctr[us][uw] == 2'b00) ? 2'b00 : mctr[us][uw] - 2'd1;
        if (ut) begin mtgt[us][uw] = utg; mlane[us][uw] = upc[3:2]; end
      end else begin
        uw = mrr[us];
        mv[us][uw] = 1; mtag[us][uw] = upc[31:7]; mtgt[us][uw] = utg;
        mlane[us][uw] = upc[3:2]; mctr[us][uw] = ut ? 2'b10 : 2'b01;
        mrr[us] = (mrr[us] + 1) % NW;
      end
    end
    @(posedge clk);
  endtask

  task automatic req(input logic [31:0] a, input string rq);
    step(1, a, 0, 0, 0, 0, 0, 0, rq);
  endtask
  task automatic rsp(input string rq);
    step(0, 0, 1, 0, 0, 0, 0, 0, rq);
  endtask
  task automatic req_rsp(input logic [31:0] a, input string rq);
    req(a, rq); rsp(rq);
  endtask
  task automatic upd(input logic [31:0] pc, input bit t, input logic [31:0] tg, input string rq);
    step(0, 0, 0, 0, 1, pc, t, tg, rq);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      mrr[s] = 0;
      for (int w = 0; w < NW; w++) mv[s][w] = 0;
    end
    rst_n = 1'b0;
    req_val = 1; req_addr = 32'h1000; rsp_val = 0; flush = 0;
    upd_val = 0; upd_pc = 0; upd_taken = 0; upd_target = 0;
    // R1: state while held in reset
    @(negedge clk); #1;
    chk(req_rdy == 1'b1, "R1", "req_rdy in reset", 32'(req_rdy), 1);
    chk(pred_val == 1'b0, "R1", "pred_val in reset", 32'(pred_val), 0);
    chk(rsp_lane_active == 4'hF, "R1", "lane_active in reset", 32'(rsp_lane_active), 32'hF);
    chk(rsp_lane_pred_taken == 4'h0, "R1", "lane_pred_taken in reset",
        32'(rsp_lane_pred_taken), 0);
    @(negedge clk); rst_n = 1'b1; req_val = 0;

    req_rsp(32'h1000, "R1");
    // R4/R2/R8: taken allocation at lane 2 then predicted redirect and masking
    upd(32'h1008, 1, 32'h2000, "R4");
    req_rsp(32'h1000, "R2 R8");
    // R3/R5: counter walk including both saturation limits
    upd(32'h1008, 0, 32'h2000, "R5");
    req_rsp(32'h1000, "R3");
    upd(32'h1008, 0, 32'h2000, "R5");
    upd(32'h1008, 0, 32'h2000, "R5");
    upd(32'h1008, 1, 32'h2000, "R5");
    req_rsp(32'h1000, "R5 weak-nt");
    upd(32'h1008, 1, 32'h2000, "R5");
    req_rsp(32'h1000, "R5 weak-t");
    for (int k = 0; k < 3; k++) upd(32'h1008, 1, 32'h2000, "R5");
    upd(32'h1008, 0, 32'h2000, "R5");
    req_rsp(32'h1000, "R5 saturated");
    // R5: taken hit refreshes target and lane
    upd(32'h100C, 1, 32'h3000, "R5");
    req_rsp(32'h1000, "R5 refresh R8");
    // R4: not-taken allocation starts weak not-taken
    upd(32'h4004, 0, 32'h6000, "R4");
    req_rsp(32'h4000, "R4 weak-nt");
    upd(32'h4004, 1, 32'h6000, "R4");
    req_rsp(32'h4000, "R4 R8");
    // R6: allocation order in set 0, set 1 untouched
    upd(32'h1014, 1, 32'h5000, "R6");
    upd(32'h8000, 1, 32'h7000, "R6");
    req_rsp(32'h1000, "R6 evicted");
    req_rsp(32'h4000, "R6 kept");
    req_rsp(32'h8000, "R6 new R8");
    req_rsp(32'h1010, "R6 other set");
    upd(32'hC008, 0, 32'h7700, "R6");
    req_rsp(32'h4000, "R6 second eviction");
    req_rsp(32'h8000, "R6 survivor");
    // R7/R9: fill the queue, blocked request, ordered drain
    req(32'h8000, "R7");
    req(32'h1000, "R7");
    req(32'h1010, "R7");
    req(32'hC000, "R7");
    req(32'h8000, "R9 full");
    step(1, 32'h8000, 1, 0, 0, 0, 0, 0, "R9 full pop");
    step(1, 32'h1010, 1, 0, 0, 0, 0, 0, "R7 push pop");
    rsp("R7"); rsp("R7"); rsp("R7"); rsp("R7");
    // R10: flush with and without a same-cycle request
    req(32'h8000, "R10");
    req(32'h1010, "R10");
    step(1, 32'hC000, 0, 1, 0, 0, 0, 0, "R10 flush+req");
    rsp("R10"); rsp("R10 empty");
    req(32'h8000, "R10");
    step(0, 0, 0, 1, 0, 0, 0, 0, "R10 flush");
    rsp("R10 after flush");

    @(negedge clk);
    req_val = 0; rsp_val = 0; flush = 0; upd_val = 0;
    done = 1;
    summary();
    $finish;
  end

endmodule